// File: doc/BRIEF.md
# Regulator Fault Protection Sequencer

This block watches one group of regulator phases and decides how their switches are driven when something goes wrong. On every clock it takes a digitized output-voltage sample, the regulation reference and the highest permitted VID code. Each fault condition must persist for its own qualification time before it counts, and once qualified the fault is held. The block then applies the gate pattern for that fault. An undervoltage fault turns both switches off. An overvoltage fault forces the low-side switch on and keeps the high-side switch off. If the output later swings negative, the low-side switch toggles off and on to limit the bounce.

When the supply-good flag rises, the block captures the level of an offset-setting pin once. That captured level decides whether undervoltage supervision runs at all, and which overvoltage margin applies. A sustained loss of supply-good counts as lockout. Lockout stops PWM, releases every switch and clears every held fault. While an undervoltage or overvoltage fault is held, a shutdown request goes to a companion regulator.

Voltage inputs are signed 12-bit codes at 5 mV per LSB, sampled every clock. They are plain level inputs with no handshake, because the sensing front end overwrites them continuously. The default qualification counts assume a 100 MHz clock.

Top module: `vr_fault_seq`

## Requirements
- R1: Out of reset, and until supply_ok is first seen high, pwm_en, hs_en, ls_force_on and peer_shdn_req are 0 and fault_code is 3 (lockout).
- R2: The first clock edge with supply_ok high ends lockout. From then on, with no fault, pwm_en=1, hs_en=1, ls_force_on=0 and fault_code=0. ofs_lvl is captured at that same edge.
- R3: supply_ok low on LOCK_CYC (300) consecutive edges gives lockout: outputs as in R1 and every held fault cleared. A shorter dip has no effect.
- R4: vout_code < ref_code - 60 (more than 300 mV low) on UV_CYC (300) consecutive edges latches undervoltage: fault_code=1, pwm_en=0, hs_en=0, ls_force_on=0. A dip of exactly 60 codes, or a shorter dip, does not latch.
- R5: When the captured ofs_lvl is nonzero (pin not grounded), undervoltage is never latched.
- R6: vout_code > vmax_code + 30 (150 mV) on OV_CYC (100) consecutive edges latches overvoltage: fault_code=2, pwm_en=0, hs_en=0, ls_force_on=1. Exactly +30 does not trip.
- R7: When the captured ofs_lvl has bit 1 set (pin above 0.9 V), the overvoltage margin is +170 codes (850 mV) instead of +30.
- R8: Only while overvoltage is held, vout_code < -10 (-50 mV) on NV_CYC (100) consecutive edges sets ls_force_on=0. The first edge with vout_code > 0 restores ls_force_on=1. Outside overvoltage, negative samples never change ls_force_on.
- R9: peer_shdn_req is 1 exactly while an undervoltage or overvoltage fault is held.
- R10: Held faults persist while supply_ok stays high, whatever the samples do. Priority is lockout (3), then overvoltage (2), then undervoltage (1).
- R11: ofs_lvl changes after power-up have no effect until the next power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above power-on threshold |
| ofs_lvl | input | 2 | Offset pin level: 0 grounded, 1 connected below 0.9 V, 2 or 3 above 0.9 V |
| vout_code | input | 12 | Signed output sample, 5 mV/LSB |
| ref_code | input | 12 | Signed regulation reference, 5 mV/LSB |
| vmax_code | input | 12 | Signed maximum VID, 5 mV/LSB |
| hs_en | output | 1 | High-side switch permitted |
| ls_force_on | output | 1 | Low-side switch forced on |
| pwm_en | output | 1 | Normal PWM operation enabled |
| peer_shdn_req | output | 1 | Shutdown request to companion regulator |
| fault_code | output | 2 | 0 none, 1 undervoltage, 2 overvoltage, 3 lockout |

## Verification
Each debounce is held for one edge fewer than its count and then for exactly its count. A counter off by one would latch early or late, and a counter that does not restart on a gap would accept a dip that is too short. Thresholds are probed exactly at their limit, so a comparison using >= instead of > would trip there. The negative-voltage toggle is driven through its qualify and re-arm edges. A design that re-armed at zero instead of above it, or kept the low side forced off, would fail. Changing the offset pin after power-up exposes a design that tracks the pin continuously instead of capturing it once. Lockout is applied with a fault held and must clear that fault.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_UV   = 2'd1,
    FC_OV   = 2'd2,
    FC_LOCK = 2'd3
  } fault_e;

  localparam int N_DET    = 4;
  localparam int DET_LOCK = 0;
  localparam int DET_UV   = 1;
  localparam int DET_OV   = 2;
  localparam int DET_NV   = 3;
endpackage

// File: rtl/fs_debounce.sv
// Qualifies a condition that holds on CYC consecutive clock edges.
module fs_debounce #(
  parameter int CYC = 100,
  parameter int CW  = $clog2(CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  output logic qual
);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_q <= '0;
    else if (!cond)       run_q <= '0;
    else if (run_q < LAST) run_q <= run_q + 1'b1;
  end

  // fires on the CYC-th consecutive edge that sees cond
  assign qual = cond && (run_q >= LAST);
endmodule

// File: rtl/fs_compare.sv
// Window comparators on the signed voltage codes.
module fs_compare #(
  parameter int VW           = 12,
  parameter int UV_MARGIN    = 60,
  parameter int OV_MARGIN    = 30,
  parameter int OV_MARGIN_HI = 170,
  parameter int NV_TRIP      = -10
) (
  input  logic signed [VW-1:0] vout_code,
  input  logic signed [VW-1:0] ref_code,
  input  logic signed [VW-1:0] vmax_code,
  input  logic                 ofs_hi,
  output logic                 uv_c,
  output logic                 ov_c,
  output logic                 nv_c,
  output logic                 pos_c
);
  localparam int EW = VW + 2;
  localparam logic signed [EW-1:0] UVM  = EW'(UV_MARGIN);
  localparam logic signed [EW-1:0] OVL  = EW'(OV_MARGIN);
  localparam logic signed [EW-1:0] OVH  = EW'(OV_MARGIN_HI);
  localparam logic signed [EW-1:0] NVT  = EW'(NV_TRIP);
  localparam logic signed [EW-1:0] ZERO = '0;

  logic signed [EW-1:0] v_x, r_x, m_x, ov_lim;

  assign v_x    = {{2{vout_code[VW-1]}}, vout_code};
  assign r_x    = {{2{ref_code[VW-1]}},  ref_code};
  assign m_x    = {{2{vmax_code[VW-1]}}, vmax_code};
  assign ov_lim = m_x + (ofs_hi ? OVH : OVL);

  assign uv_c  = v_x < (r_x - UVM);
  assign ov_c  = v_x > ov_lim;
  assign nv_c  = v_x < NVT;
  assign pos_c = v_x > ZERO;
endmodule

// File: rtl/fs_gate_map.sv
// Maps held protection state to the switch pattern and fault code.
module fs_gate_map
  import fs_pkg::*;
(
  input  logic   por_done,
  input  logic   uv_held,
  input  logic   ov_held,
  input  logic   nv_held,
  output logic   hs_en,
  output logic   ls_force_on,
  output logic   pwm_en,
  output logic   peer_shdn_req,
  output fault_e code
);
  always_comb begin
    hs_en         = 1'b0;
    ls_force_on   = 1'b0;
    pwm_en        = 1'b0;
    peer_shdn_req = 1'b0;
    code          = FC_NONE;
    if (!por_done) begin
      code = FC_LOCK;
    end else if (ov_held) begin
      code          = FC_OV;
      ls_force_on   = !nv_held;
      peer_shdn_req = 1'b1;
    end else if (uv_held) begin
      code          = FC_UV;
      peer_shdn_req = 1'b1;
    end else begin
      hs_en  = 1'b1;
      pwm_en = 1'b1;
    end
  end
endmodule

// File: rtl/vr_fault_seq.sv
module vr_fault_seq
  import fs_pkg::*;
#(
  parameter int VW           = 12,
  parameter int LOCK_CYC     = 300,
  parameter int UV_CYC       = 300,
  parameter int OV_CYC       = 100,
  parameter int NV_CYC       = 100,
  parameter int UV_MARGIN    = 60,
  parameter int OV_MARGIN    = 30,
  parameter int OV_MARGIN_HI = 170,
  parameter int NV_TRIP      = -10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 supply_ok,
  input  logic [1:0]           ofs_lvl,
  input  logic signed [VW-1:0] vout_code,
  input  logic signed [VW-1:0] ref_code,
  input  logic signed [VW-1:0] vmax_code,
  output logic                 hs_en,
  output logic                 ls_force_on,
  output logic                 pwm_en,
  output logic                 peer_shdn_req,
  output logic [1:0]           fault_code
);
  function automatic int det_cyc(int idx);
    case (idx)
      DET_LOCK: return LOCK_CYC;
      DET_UV:   return UV_CYC;
      DET_OV:   return OV_CYC;
      default:  return NV_CYC;
    endcase
  endfunction

  logic       por_done, uv_held, ov_held, nv_held;
  logic [1:0] ofs_q;
  logic       uv_c, ov_c, nv_c, pos_c;
  logic [N_DET-1:0] det_cond, det_qual;
  fault_e     code;

  fs_compare #(
    .VW(VW), .UV_MARGIN(UV_MARGIN), .OV_MARGIN(OV_MARGIN),
    .OV_MARGIN_HI(OV_MARGIN_HI), .NV_TRIP(NV_TRIP)
  ) u_cmp (
    .vout_code(vout_code), .ref_code(ref_code), .vmax_code(vmax_code),
    .ofs_hi(ofs_q[1]), .uv_c(uv_c), .ov_c(ov_c), .nv_c(nv_c), .pos_c(pos_c)
  );

  assign det_cond[DET_LOCK] = por_done && !supply_ok;
  assign det_cond[DET_UV]   = por_done && (ofs_q == 2'd0) && uv_c;
  assign det_cond[DET_OV]   = por_done && ov_c;
  assign det_cond[DET_NV]   = ov_held && !nv_held && nv_c;

  for (genvar gi = 0; gi < N_DET; gi++) begin : g_det
    fs_debounce #(.CYC(det_cyc(gi))) u_deb (
      .clk(clk), .rst_n(rst_n), .cond(det_cond[gi]), .qual(det_qual[gi])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_done <= 1'b0;
      ofs_q    <= 2'd0;
      uv_held  <= 1'b0;
      ov_held  <= 1'b0;
      nv_held  <= 1'b0;
    end else if (det_qual[DET_LOCK]) begin
      por_done <= 1'b0;
      uv_held  <= 1'b0;
      ov_held  <= 1'b0;
      nv_held  <= 1'b0;
    end else begin
      if (!por_done && supply_ok) begin
        por_done <= 1'b1;
        ofs_q    <= ofs_lvl;
      end
      if (det_qual[DET_UV]) uv_held <= 1'b1;
      if (det_qual[DET_OV]) ov_held <= 1'b1;
      if (ov_held) begin
        if (det_qual[DET_NV])      nv_held <= 1'b1;
        else if (nv_held && pos_c) nv_held <= 1'b0;
      end
    end
  end

  fs_gate_map u_map (
    .por_done(por_done), .uv_held(uv_held), .ov_held(ov_held),
    .nv_held(nv_held), .hs_en(hs_en), .ls_force_on(ls_force_on),
    .pwm_en(pwm_en), .peer_shdn_req(peer_shdn_req), .code(code)
  );

  assign fault_code = code;
endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
  parameter int VW = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 supply_ok,
  input logic signed [VW-1:0] vout_code,
  input logic                 hs_en,
  input logic                 ls_force_on,
  input logic                 pwm_en,
  input logic                 peer_shdn_req,
  input logic [1:0]           fault_code
);
  p_lock_all_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_code == 2'd3 |-> !pwm_en && !hs_en && !ls_force_on && !peer_shdn_req);

  p_uv_both_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_code == 2'd1 |-> !hs_en && !ls_force_on && !pwm_en);

  p_ov_hs_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_code == 2'd2 |-> !hs_en && !pwm_en);

  p_ls_only_ov_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ls_force_on |-> fault_code == 2'd2);

  p_ls_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code == 2'd2 && !ls_force_on && vout_code > 0 && supply_ok) |=> ls_force_on);

  p_peer_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    peer_shdn_req == (fault_code == 2'd1 || fault_code == 2'd2));

  p_ov_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code == 2'd2 && supply_ok) |=> fault_code == 2'd2);

  p_uv_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code == 2'd1 && supply_ok) |=> fault_code != 2'd0);
endmodule

bind vr_fault_seq fs_checker #(.VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .vout_code(vout_code),
  .hs_en(hs_en), .ls_force_on(ls_force_on), .pwm_en(pwm_en),
  .peer_shdn_req(peer_shdn_req), .fault_code(fault_code)
);

// File: tb/vr_fault_seq_bench.sv
`timescale 1ns/1ps
module vr_fault_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic [1:0] ofs_lvl = 2'd0;
  logic signed [11:0] vout_code = 12'sd200;
  logic signed [11:0] ref_code  = 12'sd200;
  logic signed [11:0] vmax_code = 12'sd240;
  logic hs_en, ls_force_on, pwm_en, peer_shdn_req;
  logic [1:0] fault_code;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vr_fault_seq u_vr_fault_seq (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ofs_lvl(ofs_lvl),
    .vout_code(vout_code), .ref_code(ref_code), .vmax_code(vmax_code),
    .hs_en(hs_en), .ls_force_on(ls_force_on), .pwm_en(pwm_en),
    .peer_shdn_req(peer_shdn_req), .fault_code(fault_code)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic restart(logic [1:0] lvl);
    rst_n = 1'b0; supply_ok = 1'b0; ofs_lvl = lvl;
    vout_code = 12'sd200; ref_code = 12'sd200; vmax_code = 12'sd240;
    tick(2);
    rst_n = 1'b1;
    tick(1);
    supply_ok = 1'b1;
    tick(2);
  endtask

  task automatic t_reset_powerup();
    rst_n = 1'b0; supply_ok = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    chk("R1 code", fault_code, 3);
    chk("R1 pwm", pwm_en, 0);
    chk("R1 hs", hs_en, 0);
    chk("R1 ls", ls_force_on, 0);
    chk("R1 peer", peer_shdn_req, 0);
    supply_ok = 1'b1;
    tick(1);
    chk("R2 code", fault_code, 0);
    chk("R2 pwm", pwm_en, 1);
    chk("R2 hs", hs_en, 1);
    chk("R2 ls", ls_force_on, 0);
  endtask

  task automatic t_undervoltage();
    restart(2'd0);
    vout_code = 12'sd139;
    tick(299);
    chk("R4 short dip", fault_code, 0);
    vout_code = 12'sd200; tick(2);
    vout_code = 12'sd140;
    tick(400);
    chk("R4 boundary", fault_code, 0);
    vout_code = 12'sd139;
    tick(300);
    chk("R4 latch code", fault_code, 1);
    chk("R4 hs", hs_en, 0);
    chk("R4 ls", ls_force_on, 0);
    chk("R4 pwm", pwm_en, 0);
    chk("R9 peer uv", peer_shdn_req, 1);
    vout_code = 12'sd200;
    tick(50);
    chk("R10 uv held", fault_code, 1);
    vout_code = 12'sd271;
    tick(100);
    chk("R10 ov over uv", fault_code, 2);
    chk("R10 ls", ls_force_on, 1);
  endtask

  task automatic t_uv_disabled();
    restart(2'd1);
    vout_code = 12'sd100;
    tick(350);
    chk("R5 code", fault_code, 0);
    chk("R5 pwm", pwm_en, 1);
  endtask

  task automatic t_overvoltage_nv_lockout();
    restart(2'd0);
    vout_code = 12'sd270;
    tick(150);
    chk("R6 boundary", fault_code, 0);
    vout_code = 12'sd271;
    tick(99);
    chk("R6 short", fault_code, 0);
    tick(1);
    chk("R6 code", fault_code, 2);
    chk("R6 hs", hs_en, 0);
    chk("R6 ls", ls_force_on, 1);
    chk("R6 pwm", pwm_en, 0);
    chk("R9 peer ov", peer_shdn_req, 1);
    vout_code = -12'sd11;
    tick(99);
    chk("R8 nv short", ls_force_on, 1);
    tick(1);
    chk("R8 nv off", ls_force_on, 0);
    vout_code = 12'sd0;
    tick(5);
    chk("R8 zero stays off", ls_force_on, 0);
    vout_code = 12'sd1;
    tick(1);
    chk("R8 rearm", ls_force_on, 1);
    vout_code = -12'sd11;
    tick(400);
    chk("R10 ov priority", fault_code, 2);
    supply_ok = 1'b0;
    tick(299);
    chk("R3 short dip", fault_code, 2);
    supply_ok = 1'b1;
    tick(2);
    supply_ok = 1'b0;
    tick(300);
    chk("R3 lock code", fault_code, 3);
    chk("R3 peer", peer_shdn_req, 0);
    chk("R3 ls", ls_force_on, 0);
    vout_code = 12'sd200;
    supply_ok = 1'b1;
    tick(2);
    chk("R3 cleared", fault_code, 0);
    chk("R3 pwm", pwm_en, 1);
  endtask

  task automatic t_ov_high_margin();
    restart(2'd2);
    vout_code = 12'sd410;
    tick(150);
    chk("R7 boundary", fault_code, 0);
    vout_code = 12'sd411;
    tick(99);
    chk("R7 short", fault_code, 0);
    tick(1);
    chk("R7 code", fault_code, 2);
  endtask

  task automatic t_nv_without_ov();
    restart(2'd1);
    vout_code = -12'sd50;
    tick(300);
    chk("R8 no ov ls", ls_force_on, 0);
    chk("R8 no ov code", fault_code, 0);
  endtask

  task automatic t_offset_capture();
    restart(2'd0);
    ofs_lvl = 2'd2;
    vout_code = 12'sd340;
    tick(100);
    chk("R11 held margin", fault_code, 2);
  endtask

  initial begin
    t_reset_powerup();
    t_undervoltage();
    t_uv_disabled();
    t_overvoltage_nv_lockout();
    t_ov_high_margin();
    t_nv_without_ov();
    t_offset_capture();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule